// File: doc/BRIEF.md
# Decimal Accumulator Correction Unit

The unit corrects an 8-bit accumulator byte, together with its 8-bit high companion, after binary arithmetic has been applied to decimal digits. The digits are either packed (two BCD digits per byte) or unpacked (one digit per byte, as in ASCII digit codes). A 3-bit operation code picks one of six corrections. Four of them follow an add or a subtract, one splits a binary product into two digits, and one folds two digits into a binary value before a divide. The unit reads the 16-bit accumulator pair and the incoming carry and half-carry flags. It returns the corrected pair and the updated flags.

A caller pulses `start_i` for one cycle with the operands held steady. The result is registered and appears one clock later, marked by a single-cycle `valid_o`. The registered result then holds until the next start. The binary arithmetic before the correction and all other condition flags are handled elsewhere.

Top module: `dadj_unit`

## Requirements
- R1: Op code 0 (packed add fix), low step. If AL[3:0] > 9 or af_i = 1, then 06h is added to AL and af_o = 1. Otherwise af_o = 0. Example: 7Ch with both flags clear gives 82h, cf_o = 0, af_o = 1.
- R2: Op code 0, high step. Take the 9-bit sum after the low step. If cf_i = 1, or that sum carried out of bit 7, or its upper nibble exceeds 9, then 60h is added to AL (modulo 256) and cf_o = 1. Otherwise cf_o = 0. Example: 9Ah gives 00h with cf_o = 1.
- R3: Op code 1 (packed subtract fix) mirrors R1 and R2, with subtraction in place of addition. A borrow out of the low step stands in for the carry-out. Example: 2Fh with af_i = 1 gives 29h.
- R4: Op code 2 (unpacked add fix). If AL[3:0] > 9 or af_i = 1, then AL gets AL + 06h, AH gets AH + 1, and cf_o = af_o = 1. Otherwise AH is unchanged and cf_o = af_o = 0. AL[7:4] is always cleared. Example: 0067h gives 0007h.
- R5: Op code 3 (unpacked subtract fix) follows R4, with AL − 06h and AH − 1.
- R6: Op code 4 (product split). AH gets AL / 10 and AL gets AL mod 10. cf_o and af_o copy cf_i and af_i. Example: AL = 24h gives 0306h.
- R7: Op code 5 (digit fold). AL gets (AH × 10 + AL) modulo 256 and AH gets 00h. The flags copy the inputs. Example: 0508h gives 003Ah.
- R8: Op codes 6 and 7 are reserved. They return the input pair and the input flags unchanged.
- R9: valid_o is high exactly in the cycle after a cycle with start_i high. The outputs change only after a start.
- R10: While rst_ni is low, ax_o, cf_o, af_o and valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 3 | Correction select (codes in R1–R8) |
| ax_i | input | 16 | Accumulator pair, AH in [15:8], AL in [7:0] |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming half-carry flag |
| ax_o | output | 16 | Corrected pair, same layout as ax_i |
| cf_o | output | 1 | Updated carry flag |
| af_o | output | 1 | Updated half-carry flag |
| valid_o | output | 1 | Result valid, one cycle after start_i |

## Verification
The unit keeps no state between requests apart from the result register. A wrong correction therefore shows on ax_o, cf_o or af_o in the single cycle where valid_o rises, and it is confined to that one request. A fault in the capture enable shows instead as the outputs drifting, or valid_o staying high, in the cycle after the strobe drops. The bench checks that idle cycle after every request. Carry and borrow thresholds are exercised at the edge values 99h, 9Ah and 00h, and with preset flags.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  localparam int unsigned ACC_BYTE_W = 8;
  localparam int unsigned ACC_DIG_W  = ACC_BYTE_W / 2;
  localparam int unsigned ACC_PAIR_W = 2 * ACC_BYTE_W;
  localparam int unsigned OP_W       = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PK_ADD = 3'd0,
    OP_PK_SUB = 3'd1,
    OP_UP_ADD = 3'd2,
    OP_UP_SUB = 3'd3,
    OP_SPLIT  = 3'd4,
    OP_FOLD   = 3'd5
  } dadj_op_e;

  typedef struct packed {
    logic [ACC_BYTE_W-1:0] hi;
    logic [ACC_BYTE_W-1:0] lo;
    logic                  cf;
    logic                  af;
  } acc_res_t;
endpackage

// File: rtl/dadj_packed.sv
module dadj_packed
  import dadj_pkg::*;
(
  input  logic                  sub_i,
  input  logic [ACC_BYTE_W-1:0] al_i,
  input  logic                  cf_i,
  input  logic                  af_i,
  output logic [ACC_BYTE_W-1:0] al_o,
  output logic                  cf_o,
  output logic                  af_o
);
  localparam logic [ACC_DIG_W-1:0]  DIG_MAX = ACC_DIG_W'(9);
  localparam logic [ACC_BYTE_W:0]   LO_CORR = (ACC_BYTE_W+1)'(6);
  localparam logic [ACC_BYTE_W-1:0] HI_CORR = ACC_BYTE_W'(6) << ACC_DIG_W;

  logic                  lo_fix, hi_fix;
  logic [ACC_BYTE_W:0]   step1;
  logic [ACC_BYTE_W:0]   lo_amt;
  logic [ACC_BYTE_W-1:0] hi_amt;

  always_comb begin
    lo_fix = (al_i[ACC_DIG_W-1:0] > DIG_MAX) || af_i;
    lo_amt = lo_fix ? LO_CORR : '0;
    step1  = sub_i ? ({1'b0, al_i} - lo_amt) : ({1'b0, al_i} + lo_amt);
    // step1 top bit is the carry (add) or borrow (sub) of the low step
    hi_fix = cf_i || step1[ACC_BYTE_W] ||
             (step1[ACC_BYTE_W-1:ACC_DIG_W] > DIG_MAX);
    hi_amt = hi_fix ? HI_CORR : '0;
    al_o   = sub_i ? (step1[ACC_BYTE_W-1:0] - hi_amt)
                   : (step1[ACC_BYTE_W-1:0] + hi_amt);
    cf_o   = hi_fix;
    af_o   = lo_fix;
  end
endmodule

// File: rtl/dadj_unpacked.sv
module dadj_unpacked
  import dadj_pkg::*;
(
  input  logic                  sub_i,
  input  logic [ACC_BYTE_W-1:0] ah_i,
  input  logic [ACC_BYTE_W-1:0] al_i,
  input  logic                  af_i,
  output logic [ACC_BYTE_W-1:0] ah_o,
  output logic [ACC_BYTE_W-1:0] al_o,
  output logic                  flag_o
);
  localparam logic [ACC_DIG_W-1:0]  DIG_MAX = ACC_DIG_W'(9);
  localparam logic [ACC_BYTE_W-1:0] CORR    = ACC_BYTE_W'(6);
  localparam logic [ACC_BYTE_W-1:0] ONE     = ACC_BYTE_W'(1);

  logic                  fix;
  logic [ACC_BYTE_W-1:0] al_adj;

  always_comb begin
    fix    = (al_i[ACC_DIG_W-1:0] > DIG_MAX) || af_i;
    al_adj = al_i;
    ah_o   = ah_i;
    if (fix) begin
      al_adj = sub_i ? (al_i - CORR) : (al_i + CORR);
      ah_o   = sub_i ? (ah_i - ONE)  : (ah_i + ONE);
    end
    al_o   = {{(ACC_BYTE_W-ACC_DIG_W){1'b0}}, al_adj[ACC_DIG_W-1:0]};
    flag_o = fix;
  end
endmodule

// File: rtl/dadj_radix.sv
module dadj_radix
  import dadj_pkg::*;
(
  input  logic                  fold_i,
  input  logic [ACC_BYTE_W-1:0] ah_i,
  input  logic [ACC_BYTE_W-1:0] al_i,
  output logic [ACC_BYTE_W-1:0] ah_o,
  output logic [ACC_BYTE_W-1:0] al_o
);
  localparam logic [ACC_BYTE_W-1:0] RADIX = ACC_BYTE_W'(10);

  always_comb begin
    if (fold_i) begin
      ah_o = '0;
      al_o = ah_i * RADIX + al_i;
    end else begin
      ah_o = al_i / RADIX;
      al_o = al_i % RADIX;
    end
  end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
  import dadj_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [OP_W-1:0]       op_i,
  input  logic [ACC_PAIR_W-1:0] ax_i,
  input  logic                  cf_i,
  input  logic                  af_i,
  output logic [ACC_PAIR_W-1:0] ax_o,
  output logic                  cf_o,
  output logic                  af_o,
  output logic                  valid_o
);
  logic [ACC_BYTE_W-1:0] ah_in, al_in;
  assign ah_in = ax_i[ACC_PAIR_W-1:ACC_BYTE_W];
  assign al_in = ax_i[ACC_BYTE_W-1:0];

  logic [ACC_BYTE_W-1:0] pk_al;
  logic                  pk_cf, pk_af;
  logic [ACC_BYTE_W-1:0] up_ah, up_al;
  logic                  up_flag;
  logic [ACC_BYTE_W-1:0] rx_ah, rx_al;

  dadj_packed u_packed (
    .sub_i (op_i == OP_PK_SUB),
    .al_i  (al_in),
    .cf_i  (cf_i),
    .af_i  (af_i),
    .al_o  (pk_al),
    .cf_o  (pk_cf),
    .af_o  (pk_af)
  );

  dadj_unpacked u_unpacked (
    .sub_i  (op_i == OP_UP_SUB),
    .ah_i   (ah_in),
    .al_i   (al_in),
    .af_i   (af_i),
    .ah_o   (up_ah),
    .al_o   (up_al),
    .flag_o (up_flag)
  );

  dadj_radix u_radix (
    .fold_i (op_i == OP_FOLD),
    .ah_i   (ah_in),
    .al_i   (al_in),
    .ah_o   (rx_ah),
    .al_o   (rx_al)
  );

  acc_res_t nxt, res_q;

  always_comb begin
    nxt = '{hi: ah_in, lo: al_in, cf: cf_i, af: af_i};
    case (dadj_op_e'(op_i))
      OP_PK_ADD, OP_PK_SUB: nxt = '{hi: ah_in, lo: pk_al, cf: pk_cf, af: pk_af};
      OP_UP_ADD, OP_UP_SUB: nxt = '{hi: up_ah, lo: up_al, cf: up_flag, af: up_flag};
      OP_SPLIT, OP_FOLD:    nxt = '{hi: rx_ah, lo: rx_al, cf: cf_i, af: af_i};
      default:              ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) res_q <= nxt;
    end
  end

  assign ax_o = {res_q.hi, res_q.lo};
  assign cf_o = res_q.cf;
  assign af_o = res_q.af;
endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk
  import dadj_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic [OP_W-1:0]       op_i,
  input logic [ACC_PAIR_W-1:0] ax_i,
  input logic                  cf_i,
  input logic                  af_i,
  input logic [ACC_PAIR_W-1:0] ax_o,
  input logic                  cf_o,
  input logic                  af_o,
  input logic                  valid_o
);
  assert_valid_after_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  assert_no_spurious_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  assert_hold_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(ax_o) && $stable(cf_o) && $stable(af_o)));

  assert_unpacked_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (op_i == 3'd2 || op_i == 3'd3)) |=>
      (ax_o[ACC_BYTE_W-1:ACC_DIG_W] == '0 && cf_o == af_o));

  assert_split_digit_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd4) |=>
      (ax_o[ACC_BYTE_W-1:0] < 10 && ax_o[ACC_PAIR_W-1:ACC_BYTE_W] < 26 &&
       cf_o == $past(cf_i) && af_o == $past(af_i)));

  assert_fold_clears_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd5) |=>
      (ax_o[ACC_PAIR_W-1:ACC_BYTE_W] == '0 && cf_o == $past(cf_i)));

  assert_reserved_passthru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i > 3'd5) |=>
      (ax_o == $past(ax_i) && cf_o == $past(cf_i) && af_o == $past(af_i)));

  assert_packed_keeps_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i < 3'd2) |=>
      (ax_o[ACC_PAIR_W-1:ACC_BYTE_W] == $past(ax_i[ACC_PAIR_W-1:ACC_BYTE_W])));
endmodule

bind dadj_unit dadj_unit_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .ax_i    (ax_i),
  .cf_i    (cf_i),
  .af_i    (af_i),
  .ax_o    (ax_o),
  .cf_o    (cf_o),
  .af_o    (af_o),
  .valid_o (valid_o)
);

// File: tb/tb_dadj_unit.sv
`timescale 1ns/1ps
module tb_dadj_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] ax_i = '0;
  logic        cf_i = 1'b0, af_i = 1'b0;
  logic [15:0] ax_o;
  logic        cf_o, af_o, valid_o;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  dadj_unit dut (.*);

  // model: returns {ah, al, cf, af}
  function automatic logic [17:0] model(input int op, input int ah, input int al,
                                        input int cf, input int af);
    int t, h, c, a, lo, hi, brw;
    h = ah; t = al; c = cf; a = af;
    case (op)
      0: begin
        lo = ((al % 16) > 9) || af;
        if (lo) t = t + 6;
        hi = cf || (t > 255) || (((t % 256) / 16) > 9);
        t = t % 256;
        if (hi) t = (t + 96) % 256;
        c = hi; a = lo;
      end
      1: begin
        lo = ((al % 16) > 9) || af;
        if (lo) t = t - 6;
        brw = (t < 0);
        t = (t + 256) % 256;
        hi = cf || brw || ((t / 16) > 9);
        if (hi) t = (t - 96 + 256) % 256;
        c = hi; a = lo;
      end
      2, 3: begin
        lo = ((al % 16) > 9) || af;
        if (lo) begin
          t = (op == 2) ? t + 6 : t - 6 + 256;
          h = (op == 2) ? (h + 1) % 256 : (h + 255) % 256;
        end
        t = t % 16;
        c = lo; a = lo;
      end
      4: begin h = al / 10; t = al % 10; end
      5: begin t = (ah * 10 + al) % 256; h = 0; end
      default: ;
    endcase
    return {h[7:0], t[7:0], c[0], a[0]};
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R1/R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [17:0] act,
                       input logic [17:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual ax=%h cf=%0b af=%0b expected ax=%h cf=%0b af=%0b",
               req, act[17:2], act[1], act[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input int op, input logic [15:0] ax, input bit cf, input bit af);
    logic [17:0] exp, got;
    exp = model(op, int'(ax[15:8]), int'(ax[7:0]), int'(cf), int'(af));
    @(negedge clk_i);
    op_i = op[2:0]; ax_i = ax; cf_i = cf; af_i = af; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    got = {ax_o, cf_o, af_o};
    check(valid_o === 1'b1 && got === exp, req_of(op), got, exp);
    // R9: scramble inputs while idle; outputs must hold and valid must drop
    ax_i = 16'($urandom); op_i = 3'($urandom); cf_i = ~cf; af_i = ~af;
    @(negedge clk_i);
    got = {ax_o, cf_o, af_o};
    check(valid_o === 1'b0 && got === exp, "R9", got, exp);
  endtask

  initial begin
    void'($urandom(32'd1357));
    #3;
    // R10: reset state
    check({ax_o, cf_o, af_o, valid_o} === 19'd0, "R10", {ax_o, cf_o, af_o}, 18'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o === 1'b0 && {ax_o, cf_o, af_o} === 18'd0, "R10",
          {ax_o, cf_o, af_o}, 18'd0);

    apply(0, 16'h007C, 0, 0);  // R1: 7C -> 82
    apply(0, 16'h0009, 0, 1);  // R1: af forces low fix
    apply(0, 16'h009A, 0, 0);  // R2: -> 00, cf
    apply(0, 16'h0099, 0, 0);  // R2: no correction at 99
    apply(0, 16'h0012, 1, 0);  // R2: carry in forces high fix
    apply(1, 16'h002F, 0, 1);  // R3: 2F -> 29
    apply(1, 16'h0000, 0, 1);  // R3: borrow from low step
    apply(1, 16'h00AA, 0, 0);  // R3
    apply(2, 16'h0067, 0, 0);  // R4: 67 -> 07
    apply(2, 16'h013B, 0, 0);  // R4: carry into AH
    apply(2, 16'hFF0A, 0, 0);  // R4: AH wraps
    apply(3, 16'h030F, 0, 0);  // R5
    apply(3, 16'h0002, 0, 1);  // R5: AH wraps down
    apply(4, 16'h0024, 0, 0);  // R6: 24 -> 0306
    apply(4, 16'h00FF, 1, 1);  // R6: max
    apply(5, 16'h0508, 0, 0);  // R7: -> 003A
    apply(5, 16'hFFFF, 1, 0);  // R7: truncation
    apply(6, 16'hBEEF, 1, 0);  // R8
    apply(7, 16'h1234, 0, 1);  // R8

    for (int i = 0; i < 3000; i++) begin
      apply(int'($urandom_range(7, 0)), 16'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule